// File: doc/BRIEF.md
# Page-Buffered Byte Write Sequencer

This block is the write-side controller of a byte-wide parallel nonvolatile memory. It runs on a system clock. It samples an asynchronous host bus made of three active-low strobes (chip select, output enable and write strobe), a 16-bit address and an 8-bit data bus. When the chip is selected, the write strobe is low and output enable is high, the block sees a write. It takes the address at the start of that window and the data at its end. A pulse that is too short to count as a write is discarded.

Accepted bytes are collected in a 128-byte page buffer. The first byte of a burst fixes the page number, which is address bits [15:7]. While later strobes keep arriving inside the byte-load window, the burst stays open. When the window expires, the block enters a programming cycle. During that cycle it holds `busy` and copies every buffer entry that was loaded into a synchronous array model. All three timing limits are counted in clock cycles, so a simulation can use short values. A one-cycle-latency read port on the array model exposes what was programmed.

Top module: `page_write_seq`

## Requirements
- R1: Holding output enable low while chip select and write strobe are low stores nothing and starts no programming cycle.
- R2: The address is taken from the first cycle in which the write condition holds. The data is taken from the last cycle in which it holds, so a data change made inside the pulse is the value stored.
- R3: A write may be framed by the write strobe with chip select held low, or by chip select with the write strobe held low. Both store the byte.
- R4: The first accepted load locks the page (address bits [15:7]). A later load in the same burst to a different page is discarded and sets `pageErr`. `pageErr` stays set until the first load of the next burst clears it.
- R5: Programming starts only once LOAD_WIN clock cycles pass without a new qualified strobe after the last one. A strobe that arrives sooner keeps the burst open.
- R6: The buffer holds 128 bytes selected by address bits [6:0]. A single burst can fill all 128 of them.
- R7: A write pulse that lasts fewer than GLITCH_CYC synchronized cycles is discarded.
- R8: `busy` stays high for exactly PROG_CYC cycles. Strobes that begin during that time are discarded.
- R9: A second load to the same byte offset in one burst replaces the earlier byte.
- R10: Only offsets loaded in the current burst are written to the array. The loaded-offset record clears when programming ends.
- R11: The array word index is {page bits [PIDX-1:0], offset}, where PIDX = log2(ARRAY_PAGES). Reset fills the array with 8'hFF. `rdData` follows `rdIdx` one clock later.
- R12: After reset, `busy` and `pageErr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Active-low chip select (asynchronous) |
| oeN | input | 1 | Active-low output enable (asynchronous) |
| weN | input | 1 | Active-low write strobe (asynchronous) |
| addr | input | 16 | Byte address; [15:7] page, [6:0] offset |
| dataIn | input | 8 | Write data |
| rdIdx | input | ARR_AW | Array word index for the read port |
| rdData | output | 8 | Array word at `rdIdx`, registered |
| busy | output | 1 | High during a programming cycle |
| pageErr | output | 1 | Sticky flag for a load to a page other than the locked one |

## Verification
The assertions check the following on every clock:
- a committed load always follows a pulse of at least GLITCH_CYC cycles;
- programming is entered only once the load timer has reached its limit;
- `busy` drops only after the program counter reaches its final count;
- the locked page never changes mid-burst;
- a page mismatch always raises `pageErr`;
- the loaded-offset record is empty after every programming cycle.

Only the directed scenarios can show which address and data values end up in the array. They cover inhibit by output enable, glitch rejection, overwrite of an offset, rejection of off-page loads and loads made during `busy`, and both strobe-framing styles. They read the array back after each programming cycle.

// File: rtl/pws_pkg.sv
package pws_pkg;
  localparam int PAGE_BYTES = 128;
  localparam int OFF_W      = $clog2(PAGE_BYTES);
  localparam int ADDR_W     = 16;
  localparam int PAGE_W     = ADDR_W - OFF_W;
  localparam int DATA_W     = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } seqState_t;

  typedef struct packed {
    logic             addrCap;
    logic             dataCap;
    logic             commit;
    logic             progWr;
    logic [OFF_W-1:0] progIdx;
    logic             progDone;
  } seqStrb_t;
endpackage

// File: rtl/pws_ctrl.sv
module pws_ctrl
  import pws_pkg::*;
#(
  parameter int GLITCH_CYC  = 3,
  parameter int LOAD_WIN    = 5000,
  parameter int PROG_CYC    = 500000,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     ceN,
  input  logic     oeN,
  input  logic     weN,
  output seqStrb_t strb,
  output logic     busy
);
  localparam int GW = $clog2(GLITCH_CYC + 1);
  localparam int TW = $clog2(LOAD_WIN + 1);
  localparam int PW = $clog2(PROG_CYC + 1);

  logic [SYNC_STAGES-1:0] ceSync, oeSync, weSync;
  logic active, activeQ, blocked, pulseOk, qualify, releaseEdge, expire;
  logic [GW-1:0] pulseCnt;
  logic [TW-1:0] loadTmr;
  logic [PW-1:0] progCnt;
  seqState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ceSync <= '1;
      oeSync <= '1;
      weSync <= '1;
    end else begin
      ceSync <= {ceSync[SYNC_STAGES-2:0], ceN};
      oeSync <= {oeSync[SYNC_STAGES-2:0], oeN};
      weSync <= {weSync[SYNC_STAGES-2:0], weN};
    end
  end

  always_comb begin
    active      = !ceSync[SYNC_STAGES-1] && !weSync[SYNC_STAGES-1] && oeSync[SYNC_STAGES-1];
    qualify     = active && !blocked && !pulseOk && (state != ST_PROG) &&
                  (pulseCnt == GW'(GLITCH_CYC - 1));
    releaseEdge = activeQ && !active;
    expire      = (state == ST_LOAD) && !active && !pulseOk &&
                  (loadTmr == TW'(LOAD_WIN - 1));
  end

  // pulse length filter and blocking of strobes that begin while programming
  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ  <= 1'b0;
      pulseCnt <= '0;
      pulseOk  <= 1'b0;
      blocked  <= 1'b0;
    end else begin
      activeQ <= active;
      if (!active) pulseCnt <= '0;
      else if (pulseCnt != GW'(GLITCH_CYC - 1)) pulseCnt <= pulseCnt + 1'b1;
      if (!active) pulseOk <= 1'b0;
      else if (qualify) pulseOk <= 1'b1;
      if (!active) blocked <= 1'b0;
      else if (state == ST_PROG) blocked <= 1'b1;
    end
  end

  always_comb begin
    strb.addrCap  = active && !activeQ;
    strb.dataCap  = active;
    strb.commit   = releaseEdge && pulseOk && (state != ST_PROG);
    strb.progWr   = (state == ST_PROG) && (progCnt < PW'(PAGE_BYTES));
    strb.progIdx  = progCnt[OFF_W-1:0];
    strb.progDone = (state == ST_PROG) && (progCnt == PW'(PROG_CYC - 1));
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (strb.commit) stateNext = ST_LOAD;
      ST_LOAD: if (expire) stateNext = ST_PROG;
      ST_PROG: if (strb.progDone) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      loadTmr <= '0;
      progCnt <= '0;
    end else begin
      state <= stateNext;
      if (state != ST_LOAD || qualify) loadTmr <= '0;
      else if (!active && loadTmr != TW'(LOAD_WIN - 1)) loadTmr <= loadTmr + 1'b1;
      if (state == ST_PROG && !strb.progDone) progCnt <= progCnt + 1'b1;
      else progCnt <= '0;
    end
  end

  assign busy = (state == ST_PROG);

  // independent run-length counter used only by the glitch assertion
  logic [GW-1:0] lowRun;
  always_ff @(posedge clk) begin
    if (!rstN) lowRun <= '0;
    else if (!active) lowRun <= '0;
    else if (lowRun != GW'(GLITCH_CYC)) lowRun <= lowRun + 1'b1;
  end

  assert_glitch_reject_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> (lowRun >= GW'(GLITCH_CYC)));

  assert_load_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOAD) && (stateNext == ST_PROG) |-> (loadTmr == TW'(LOAD_WIN - 1)));

  assert_prog_length_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && progCnt != PW'(PROG_CYC - 1)) |=> busy);
endmodule

// File: rtl/pws_array.sv
module pws_array #(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [AW-1:0]     wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [AW-1:0]     rdIdx,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      rdData <= '1;
    end else begin
      if (wrEn) mem[wrIdx] <= wrData;
      rdData <= mem[rdIdx];
    end
  end
endmodule

// File: rtl/pws_dpath.sv
module pws_dpath
  import pws_pkg::*;
#(
  parameter int ARRAY_PAGES = 4,
  parameter int SYNC_STAGES = 2,
  localparam int PIDX_W     = $clog2(ARRAY_PAGES),
  localparam int ARR_AW     = PIDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  seqStrb_t          strb,
  input  logic [ARR_AW-1:0] rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic              pageErr
);
  logic [ADDR_W-1:0] addrPipe [SYNC_STAGES];
  logic [DATA_W-1:0] dataPipe [SYNC_STAGES];
  logic [ADDR_W-1:0] addrHold;
  logic [DATA_W-1:0] dataHold;
  logic [PAGE_W-1:0] lockPage, curPage;
  logic [OFF_W-1:0]  curOff;
  logic              locked, accept, reject;
  logic [PAGE_BYTES-1:0] validMask;
  logic [DATA_W-1:0] pageBuf [PAGE_BYTES];

  // address and data take the same path depth as the strobes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) begin
        addrPipe[i] <= '0;
        dataPipe[i] <= '0;
      end
      addrHold <= '0;
      dataHold <= '0;
    end else begin
      addrPipe[0] <= addr;
      dataPipe[0] <= dataIn;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        addrPipe[i] <= addrPipe[i-1];
        dataPipe[i] <= dataPipe[i-1];
      end
      if (strb.addrCap) addrHold <= addrPipe[SYNC_STAGES-1];
      if (strb.dataCap) dataHold <= dataPipe[SYNC_STAGES-1];
    end
  end

  always_comb begin
    curPage = addrHold[ADDR_W-1:OFF_W];
    curOff  = addrHold[OFF_W-1:0];
    accept  = strb.commit && (!locked || curPage == lockPage);
    reject  = strb.commit && locked && (curPage != lockPage);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      locked    <= 1'b0;
      lockPage  <= '0;
      validMask <= '0;
      pageErr   <= 1'b0;
    end else begin
      if (accept) begin
        validMask[curOff] <= 1'b1;
        if (!locked) begin
          locked   <= 1'b1;
          lockPage <= curPage;
          pageErr  <= 1'b0;
        end
      end
      if (reject) pageErr <= 1'b1;
      if (strb.progDone) begin
        validMask <= '0;
        locked    <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) pageBuf[curOff] <= dataHold;
  end

  pws_array #(
    .DEPTH (ARRAY_PAGES * PAGE_BYTES),
    .DATA_W(DATA_W)
  ) u_array (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (strb.progWr && validMask[strb.progIdx]),
    .wrIdx ({lockPage[PIDX_W-1:0], strb.progIdx}),
    .wrData(pageBuf[strb.progIdx]),
    .rdIdx (rdIdx),
    .rdData(rdData)
  );

  assert_lock_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (locked && !strb.progDone) |=> $stable(lockPage));

  assert_mismatch_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && locked && (addrHold[ADDR_W-1:OFF_W] != lockPage)) |=> pageErr);

  assert_mask_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.progDone |=> (validMask == '0 && !locked));
endmodule

// File: rtl/page_write_seq.sv
module page_write_seq
  import pws_pkg::*;
#(
  parameter int GLITCH_CYC  = 3,
  parameter int LOAD_WIN    = 5000,
  parameter int PROG_CYC    = 500000,
  parameter int ARRAY_PAGES = 4,
  localparam int ARR_AW     = $clog2(ARRAY_PAGES) + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [15:0]       addr,
  input  logic [7:0]        dataIn,
  input  logic [ARR_AW-1:0] rdIdx,
  output logic [7:0]        rdData,
  output logic              busy,
  output logic              pageErr
);
  localparam int SYNC_STAGES = 2;

  seqStrb_t strb;

  pws_ctrl #(
    .GLITCH_CYC (GLITCH_CYC),
    .LOAD_WIN   (LOAD_WIN),
    .PROG_CYC   (PROG_CYC),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk (clk),
    .rstN(rstN),
    .ceN (ceN),
    .oeN (oeN),
    .weN (weN),
    .strb(strb),
    .busy(busy)
  );

  pws_dpath #(
    .ARRAY_PAGES(ARRAY_PAGES),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .addr   (addr),
    .dataIn (dataIn),
    .strb   (strb),
    .rdIdx  (rdIdx),
    .rdData (rdData),
    .pageErr(pageErr)
  );
endmodule

// File: tb/tb_page_write_seq.sv
module tb_page_write_seq;
  localparam int GL = 3;
  localparam int LW = 40;
  localparam int PC = 200;
  localparam int AP = 4;
  localparam int AW = $clog2(AP) + 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0] dataIn = '0;
  logic [AW-1:0] rdIdx = '0;
  logic [7:0] rdData;
  logic busy, pageErr;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  page_write_seq #(.GLITCH_CYC(GL), .LOAD_WIN(LW), .PROG_CYC(PC), .ARRAY_PAGES(AP)) dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .addr(addr),
    .dataIn(dataIn), .rdIdx(rdIdx), .rdData(rdData), .busy(busy), .pageErr(pageErr));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mkAddr(int page, int off);
    return 16'((page << 7) | off);
  endfunction

  task automatic readArr(int page, int off, output int val);
    @(negedge clk);
    rdIdx = AW'(((page % AP) << 7) | off);
    @(negedge clk);
    @(negedge clk);
    val = rdData;
  endtask

  task automatic weWrite(int page, int off, int d);
    @(negedge clk);
    addr = mkAddr(page, off); dataIn = 8'(d); ceN = 1'b0; oeN = 1'b1;
    repeat (2) @(negedge clk);
    weN = 1'b0;
    repeat (8) @(negedge clk);
    weN = 1'b1;
    @(negedge clk);
    ceN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic ceWrite(int page, int off, int d);
    @(negedge clk);
    addr = mkAddr(page, off); dataIn = 8'(d); weN = 1'b0; oeN = 1'b1;
    repeat (2) @(negedge clk);
    ceN = 1'b0;
    repeat (8) @(negedge clk);
    ceN = 1'b1;
    @(negedge clk);
    weN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic waitProg(output int riseWait, output int len);
    riseWait = 0;
    while (busy !== 1'b1 && riseWait < 400) begin @(negedge clk); riseWait++; end
    len = 0;
    while (busy === 1'b1 && len < 1000) begin @(negedge clk); len++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic quietFor(int n, output int sawBusy);
    sawBusy = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (busy === 1'b1) sawBusy = 1;
    end
  endtask

  task automatic testReset();
    int v;
    chk("R12 busy after reset", busy, 0);
    chk("R12 pageErr after reset", pageErr, 0);
    readArr(0, 0, v);
    chk("R11 array erased after reset", v, 8'hFF);
  endtask

  task automatic testWeFramed();
    int v, rw, len;
    weWrite(1, 3, 8'h3C);
    repeat (20) @(negedge clk);
    chk("R5 window still open 24 cycles after release", busy, 0);
    waitProg(rw, len);
    chk("R5 programming starts after window", int'(rw >= 5 && rw <= 40), 1);
    chk("R8 busy length equals PROG_CYC", len, PC);
    readArr(1, 3, v);
    chk("R3 write-strobe framed byte stored", v, 8'h3C);
  endtask

  task automatic testCeFramed();
    int v, rw, len;
    ceWrite(1, 4, 8'h4D);
    waitProg(rw, len);
    readArr(1, 4, v);
    chk("R3 chip-select framed byte stored", v, 8'h4D);
  endtask

  task automatic testCapture();
    int v, rw, len;
    @(negedge clk);
    addr = mkAddr(2, 10); dataIn = 8'h11; ceN = 1'b0; oeN = 1'b1;
    repeat (2) @(negedge clk);
    weN = 1'b0;
    repeat (4) @(negedge clk);
    addr = mkAddr(2, 20); dataIn = 8'h99;
    repeat (6) @(negedge clk);
    weN = 1'b1;
    @(negedge clk);
    ceN = 1'b1;
    waitProg(rw, len);
    readArr(2, 10, v);
    chk("R2 start address with end data", v, 8'h99);
    readArr(2, 20, v);
    chk("R2 late address not used", v, 8'hFF);
  endtask

  task automatic testGlitch();
    int v, saw;
    @(negedge clk);
    addr = mkAddr(0, 1); dataIn = 8'h77; ceN = 1'b0;
    repeat (2) @(negedge clk);
    weN = 1'b0;
    repeat (2) @(negedge clk);
    weN = 1'b1;
    @(negedge clk);
    ceN = 1'b1;
    quietFor(100, saw);
    chk("R7 short pulse starts no programming", saw, 0);
    readArr(0, 1, v);
    chk("R7 short pulse stores nothing", v, 8'hFF);
  endtask

  task automatic testInhibit();
    int v, saw;
    @(negedge clk);
    addr = mkAddr(0, 2); dataIn = 8'h22; oeN = 1'b0; ceN = 1'b0;
    repeat (2) @(negedge clk);
    weN = 1'b0;
    repeat (8) @(negedge clk);
    weN = 1'b1;
    @(negedge clk);
    ceN = 1'b1; oeN = 1'b1;
    quietFor(100, saw);
    chk("R1 output enable low inhibits programming", saw, 0);
    readArr(0, 2, v);
    chk("R1 output enable low stores nothing", v, 8'hFF);
  endtask

  task automatic testBurst();
    int v, rw, len;
    weWrite(3, 0, 8'h10);
    repeat (16) @(negedge clk);
    chk("R5 burst open between loads", busy, 0);
    weWrite(3, 127, 8'h7F);
    repeat (16) @(negedge clk);
    chk("R5 burst open after second load", busy, 0);
    weWrite(3, 0, 8'hA0);
    waitProg(rw, len);
    readArr(3, 0, v);
    chk("R9 repeated offset keeps last byte", v, 8'hA0);
    readArr(3, 127, v);
    chk("R6 top offset stored", v, 8'h7F);
    readArr(3, 64, v);
    chk("R10 unloaded offset untouched", v, 8'hFF);
  endtask

  task automatic testLock();
    int v, rw, len;
    weWrite(1, 50, 8'h50);
    weWrite(2, 51, 8'h51);
    repeat (2) @(negedge clk);
    chk("R4 off-page load raises pageErr", pageErr, 1);
    waitProg(rw, len);
    chk("R4 pageErr sticky after programming", pageErr, 1);
    readArr(1, 50, v);
    chk("R4 locked page byte stored", v, 8'h50);
    readArr(2, 51, v);
    chk("R4 off-page byte not stored", v, 8'hFF);
    readArr(1, 51, v);
    chk("R4 off-page byte not redirected", v, 8'hFF);
    weWrite(0, 9, 8'h09);
    repeat (2) @(negedge clk);
    chk("R4 next burst clears pageErr", pageErr, 0);
    waitProg(rw, len);
    readArr(0, 50, v);
    chk("R10 previous burst offsets not replayed", v, 8'hFF);
    readArr(0, 9, v);
    chk("R11 page 0 index mapping", v, 8'h09);
  endtask

  task automatic testBusyReject();
    int v, rw, len, saw;
    weWrite(2, 30, 8'h30);
    rw = 0;
    while (busy !== 1'b1 && rw < 400) begin @(negedge clk); rw++; end
    weWrite(2, 31, 8'h31);
    waitProg(rw, len);
    quietFor(100, saw);
    chk("R8 load during busy starts no new cycle", saw, 0);
    readArr(2, 31, v);
    chk("R8 load during busy discarded", v, 8'hFF);
    readArr(2, 30, v);
    chk("R8 byte before busy stored", v, 8'h30);
  endtask

  task automatic testFullPage();
    int v, rw, len;
    for (int i = 0; i < 128; i++) weWrite(0, i, (i ^ 8'hC3) & 8'hFF);
    waitProg(rw, len);
    chk("R8 full page programming length", len, PC);
    for (int i = 0; i < 128; i++) begin
      readArr(0, i, v);
      chk("R6 full page byte", v, (i ^ 8'hC3) & 8'hFF);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testWeFramed();
    testCeFramed();
    testCapture();
    testGlitch();
    testInhibit();
    testBurst();
    testLock();
    testBusyReject();
    testFullPage();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule